// File: doc/BRIEF.md
# Write-combining line buffer

This block gathers stores aimed at write-combining memory into a single 64-byte line held on chip. A store carries a beat-aligned address, eight data bytes and a byte-enable. When it falls inside the line already being gathered, its enabled bytes are merged into that line. A later write to a byte replaces the earlier value, so only the newest value of each byte ever reaches memory. The gathered data never goes into a data cache. It leaves the block only when the line is drained onto a bus write port.

A drain starts in three cases: a store names a different line, the `flush` input is raised, or every byte of the line has been written. During a drain the line goes out as masked 8-byte beats in ascending address order, one per cycle. Beats that hold no written byte are skipped. This order is set by the address and has nothing to do with the order of the stores. While a drain is running, `busy` is high and no store is accepted.

The controller has three states. **EMPTY** holds no line. **FILL** holds an open line. **DRAIN** emits beats. Transitions:
- EMPTY→FILL: a store is accepted.
- EMPTY→DRAIN: the accepted store arrives together with `flush`.
- FILL→FILL: a store to the same line merges.
- FILL→DRAIN: a store to another line arrives, or `flush` is raised, or the line becomes full.
- DRAIN→DRAIN: non-empty beats remain after the current one.
- DRAIN→EMPTY: the last non-empty beat has been emitted, or no non-empty beat was found.

Top module: `wc_line_buffer`

## Requirements
- R1: After reset the buffer is empty: `busy` and `bus_valid` are low and `st_ready` is high.
- R2: A store offered while the buffer is empty is accepted in that cycle, and its line becomes the open line.
- R3: Stores to the open line merge byte by byte. A byte written more than once is emitted only with its last value.
- R4: A store to a different line while a line is open sees `st_ready` low. The open line drains, and the store is accepted in the first cycle after the drain, provided it is still offered.
- R5: `flush` drains a partly written open line. `flush` with no open line and no store has no effect: no beat appears and `st_ready` stays high.
- R6: When a store completes all 64 bytes of the line, the drain starts in the next cycle without `flush`.
- R7: A drain emits one beat per cycle, in ascending address order, with no gaps. It skips beats with no written byte, and each `bus_mask` bit marks a written byte.
- R8: `busy` is high exactly while draining, and `st_ready` is low for that whole time.
- R9: `bus_addr` is the line base plus 8 times the beat index, with bits [2:0] zero. Byte i of `bus_data` is bits [8i+7:8i], and its valid flag is `bus_mask[i]`.
- R10: `st_be[i]` enables byte i, which is bits [8i+7:8i] of `st_data`. `st_addr` bits [5:3] select the beat within the line, and the bits above them form the line tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | 29 | Store address bits [31:3] (beat-aligned) |
| st_data | input | 64 | Store data, 8 bytes |
| st_be | input | 8 | Store byte-enable |
| flush | input | 1 | Force a drain of the open line |
| st_ready | output | 1 | Store accepted in this cycle |
| bus_valid | output | 1 | Beat valid on the bus port |
| bus_addr | output | 32 | Byte address of the beat |
| bus_data | output | 64 | Beat data |
| bus_mask | output | 8 | Beat byte mask |
| busy | output | 1 | Drain in progress |

## Verification
The bench carries a behavioural model of the line and compares the block with it on every cycle. Sparse stores with mixed byte-enables across beats 0 and 7 check merging, overwriting and the skipping of empty beats. Eight full-beat stores check the automatic drain on a full line, as distinct from a `flush`. A store to a second line that is held high through the stall shows the drain-then-open order and the stalled `st_ready`. A long stretch of random stores across two lines, with random flushes, covers combinations of stalls, overwrites and flushes that the directed cases miss.

// File: rtl/wc_pkg.sv
package wc_pkg;
    typedef enum logic [1:0] {
        WC_EMPTY = 2'd0,
        WC_FILL  = 2'd1,
        WC_DRAIN = 2'd2
    } wc_state_e;
endpackage

// File: rtl/wc_line_store.sv
// Byte storage of the open line with per-byte written flags.
module wc_line_store #(
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 8,
    localparam int NBEATS = LINE_BYTES / BEAT_BYTES,
    localparam int BEAT_W = $clog2(NBEATS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [BEAT_W-1:0]         wr_beat,
    input  logic [BEAT_BYTES*8-1:0]   wr_data,
    input  logic [BEAT_BYTES-1:0]     wr_be,
    input  logic                      clr_en,
    input  logic [BEAT_W-1:0]         clr_beat,
    output logic [LINE_BYTES*8-1:0]   line_data,
    output logic [LINE_BYTES-1:0]     line_mask
);
    for (genvar b = 0; b < NBEATS; b++) begin : g_beat
        for (genvar y = 0; y < BEAT_BYTES; y++) begin : g_byte
            localparam int IDX = b * BEAT_BYTES + y;
            logic       vld_q;
            logic [7:0] dat_q;
            logic       hit;

            assign hit = wr_en && (wr_beat == BEAT_W'(b)) && wr_be[y];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                end else if (hit) begin
                    vld_q <= 1'b1;
                end else if (clr_en && (clr_beat == BEAT_W'(b))) begin
                    vld_q <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (hit) begin
                    dat_q <= wr_data[y*8 +: 8];
                end
            end

            assign line_mask[IDX]         = vld_q;
            assign line_data[IDX*8 +: 8]  = dat_q;
        end
    end
endmodule

// File: rtl/wc_beat_pick.sv
// Picks the lowest beat that still holds written bytes.
module wc_beat_pick #(
    parameter int NBEATS = 8,
    localparam int BEAT_W = $clog2(NBEATS)
) (
    input  logic [NBEATS-1:0] nz,
    output logic [BEAT_W-1:0] sel,
    output logic              found,
    output logic              more
);
    always_comb begin
        found = |nz;
        sel   = '0;
        for (int i = NBEATS - 1; i >= 0; i--) begin
            if (nz[i]) begin
                sel = BEAT_W'(i);
            end
        end
        more = |(nz & ~(NBEATS'(1) << sel));
    end
endmodule

// File: rtl/wc_line_buffer.sv
module wc_line_buffer #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  st_valid,
    input  logic [ADDR_W-1:$clog2(BEAT_BYTES)]    st_addr,
    input  logic [BEAT_BYTES*8-1:0]               st_data,
    input  logic [BEAT_BYTES-1:0]                 st_be,
    input  logic                                  flush,
    output logic                                  st_ready,
    output logic                                  bus_valid,
    output logic [ADDR_W-1:0]                     bus_addr,
    output logic [BEAT_BYTES*8-1:0]               bus_data,
    output logic [BEAT_BYTES-1:0]                 bus_mask,
    output logic                                  busy
);
    import wc_pkg::*;

    localparam int NBEATS = LINE_BYTES / BEAT_BYTES;
    localparam int BEAT_W = $clog2(NBEATS);
    localparam int OFF_W  = $clog2(BEAT_BYTES);
    localparam int LOFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - LOFF_W;
    localparam int DATA_W = BEAT_BYTES * 8;

    wc_state_e              state_q, state_d;
    logic [TAG_W-1:0]       tag_q;
    logic [TAG_W-1:0]       st_tag;
    logic [BEAT_W-1:0]      st_beat;
    logic                   same_line;
    logic                   accept;
    logic [LINE_BYTES*8-1:0] line_data;
    logic [LINE_BYTES-1:0]  line_mask;
    logic [LINE_BYTES-1:0]  wr_line_mask;
    logic                   full_next;
    logic [NBEATS-1:0]      beat_nz;
    logic [BEAT_W-1:0]      pick_sel;
    logic                   pick_found;
    logic                   pick_more;
    logic                   clr_en;
    logic [DATA_W-1:0]      sel_data;
    logic [BEAT_BYTES-1:0]  sel_mask;

    assign st_tag    = st_addr[ADDR_W-1:LOFF_W];
    assign st_beat   = st_addr[LOFF_W-1:OFF_W];
    assign same_line = (tag_q == st_tag);
    assign accept    = st_valid && st_ready;
    assign clr_en    = (state_q == WC_DRAIN) && pick_found;

    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_wmask
        assign wr_line_mask[i] = accept && (st_beat == BEAT_W'(i / BEAT_BYTES))
                                 && st_be[i % BEAT_BYTES];
    end

    for (genvar b = 0; b < NBEATS; b++) begin : g_nz
        assign beat_nz[b] = |line_mask[b*BEAT_BYTES +: BEAT_BYTES];
    end

    assign full_next = &(line_mask | wr_line_mask);

    wc_line_store #(
        .LINE_BYTES (LINE_BYTES),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_beat   (st_beat),
        .wr_data   (st_data),
        .wr_be     (st_be),
        .clr_en    (clr_en),
        .clr_beat  (pick_sel),
        .line_data (line_data),
        .line_mask (line_mask)
    );

    wc_beat_pick #(
        .NBEATS (NBEATS)
    ) u_pick (
        .nz    (beat_nz),
        .sel   (pick_sel),
        .found (pick_found),
        .more  (pick_more)
    );

    always_comb begin
        sel_data = '0;
        sel_mask = '0;
        for (int b = 0; b < NBEATS; b++) begin
            if (BEAT_W'(b) == pick_sel) begin
                sel_data = line_data[b*DATA_W +: DATA_W];
                sel_mask = line_mask[b*BEAT_BYTES +: BEAT_BYTES];
            end
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WC_EMPTY: begin
                if (accept) begin
                    state_d = (flush || full_next) ? WC_DRAIN : WC_FILL;
                end
            end
            WC_FILL: begin
                if (st_valid && !same_line) begin
                    state_d = WC_DRAIN;
                end else if (flush || full_next) begin
                    state_d = WC_DRAIN;
                end
            end
            WC_DRAIN: begin
                if (!pick_more) begin
                    state_d = WC_EMPTY;
                end
            end
            default: state_d = WC_EMPTY;
        endcase
    end

    // state register and line tag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WC_EMPTY;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WC_EMPTY && accept) begin
                tag_q <= st_tag;
            end
        end
    end

    // outputs
    always_comb begin
        st_ready  = 1'b0;
        busy      = 1'b0;
        bus_valid = 1'b0;
        bus_addr  = '0;
        bus_data  = '0;
        bus_mask  = '0;
        unique case (state_q)
            WC_EMPTY: st_ready = 1'b1;
            WC_FILL:  st_ready = same_line;
            WC_DRAIN: begin
                busy      = 1'b1;
                bus_valid = pick_found;
                if (pick_found) begin
                    bus_addr = {tag_q, pick_sel, {OFF_W{1'b0}}};
                    bus_data = sel_data;
                    bus_mask = sel_mask;
                end
            end
            default: st_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/wc_line_buffer_chk.sv
module wc_line_buffer_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 8,
    localparam int OFF_W     = $clog2(BEAT_BYTES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   st_ready,
    input logic                   busy,
    input logic                   bus_valid,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [BEAT_BYTES-1:0]  bus_mask,
    input logic [LINE_BYTES-1:0]  line_mask
);
    a_r8_no_accept_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !st_ready);

    a_r8_beat_only_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> busy);

    a_r7_beat_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_mask != '0));

    a_r7_ascending_beats: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && $past(bus_valid)) |-> (bus_addr > $past(bus_addr)));

    a_r9_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr[OFF_W-1:0] == '0));

    a_r7_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (line_mask == '0));
endmodule

bind wc_line_buffer wc_line_buffer_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .BEAT_BYTES (BEAT_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_ready  (st_ready),
    .busy      (busy),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_mask  (bus_mask),
    .line_mask (line_mask)
);

// File: tb/wc_line_buffer_test.sv
module wc_line_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int LB = 64;
    localparam int BB = 8;
    localparam int NB = 8;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [31:3] st_addr = '0;
    logic [63:0] st_data = '0;
    logic [7:0]  st_be = '0;
    logic        flush = 1'b0;
    logic        st_ready, bus_valid, busy;
    logic [31:0] bus_addr;
    logic [63:0] bus_data;
    logic [7:0]  bus_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    wc_line_buffer uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .flush(flush), .st_ready(st_ready),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_mask(bus_mask), .busy(busy)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model: 0 empty, 1 open, 2 draining
    int          m_state = 0;
    logic [25:0] m_tag = '0;
    bit          m_mask [LB];
    logic [7:0]  m_data [LB];

    function automatic int first_beat();
        for (int b = 0; b < NB; b++)
            for (int y = 0; y < BB; y++)
                if (m_mask[b*BB+y]) return b;
        return -1;
    endfunction

    function automatic bit line_full();
        for (int i = 0; i < LB; i++) if (!m_mask[i]) return 0;
        return 1;
    endfunction

    function automatic bit m_ready();
        return (m_state == 0) || (m_state == 1 && st_addr[31:6] == m_tag);
    endfunction

    function automatic void merge();
        for (int y = 0; y < BB; y++)
            if (st_be[y]) begin
                m_mask[int'(st_addr[5:3])*BB+y] = 1;
                m_data[int'(st_addr[5:3])*BB+y] = st_data[y*8 +: 8];
            end
    endfunction

    task automatic chk(string f, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, f, act, exp);
        end
    endtask

    task automatic step();
        bit r, acc;
        int fb;
        logic [7:0]  em;
        logic [63:0] ed, bm;
        #1;
        r  = m_ready();
        fb = (m_state == 2) ? first_beat() : -1;
        chk("st_ready", 64'(st_ready), 64'(r));
        chk("busy", 64'(busy), 64'(m_state == 2));
        chk("bus_valid", 64'(bus_valid), 64'(fb >= 0));
        if (fb >= 0) begin
            em = '0; ed = '0; bm = '0;
            for (int y = 0; y < BB; y++)
                if (m_mask[fb*BB+y]) begin
                    em[y] = 1'b1;
                    ed[y*8 +: 8] = m_data[fb*BB+y];
                    bm[y*8 +: 8] = 8'hff;
                end
            chk("bus_addr", 64'(bus_addr), 64'({m_tag, 3'(fb), 3'b000}));
            chk("bus_mask", 64'(bus_mask), 64'(em));
            chk("bus_data", bus_data & bm, ed);
        end
        acc = st_valid && r;
        @(posedge clk);
        case (m_state)
            0: if (acc) begin
                   m_tag = st_addr[31:6];
                   merge();
                   m_state = (flush || line_full()) ? 2 : 1;
               end
            1: if (st_valid && st_addr[31:6] != m_tag) m_state = 2;
               else begin
                   if (acc) merge();
                   if (flush || line_full()) m_state = 2;
               end
            default: begin
                if (fb >= 0) for (int y = 0; y < BB; y++) m_mask[fb*BB+y] = 0;
                if (first_beat() < 0) m_state = 0;
            end
        endcase
        @(negedge clk);
    endtask

    task automatic idle(int n);
        st_valid = 0; flush = 0;
        repeat (n) step();
    endtask

    task automatic store(logic [31:0] a, logic [63:0] d, logic [7:0] be, bit fl);
        bit r;
        st_valid = 1; st_addr = a[31:3]; st_data = d; st_be = be; flush = fl;
        forever begin
            r = m_ready();
            step();
            if (r) break;
        end
        st_valid = 0; flush = 0;
    endtask

    task automatic flush_now();
        st_valid = 0; flush = 1;
        step();
        flush = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL R8 watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LB; i++) begin m_mask[i] = 0; m_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        idle(3);

        // single store then flush; unaligned byte bits are not on the port
        cur_req = "R2";
        store(32'h0000_1048, 64'h1122_3344_5566_7788, 8'h0f, 0);
        cur_req = "R5";
        flush_now();
        cur_req = "R9";
        idle(4);

        // R3 merge and overwrite across beats 0 and 7, sparse enables (R10)
        cur_req = "R3";
        store(32'h0000_2000, 64'haaaa_aaaa_aaaa_aaaa, 8'hff, 0);
        store(32'h0000_2038, 64'h0102_0304_0506_0708, 8'h81, 0);
        store(32'h0000_2000, 64'hbbbb_bbbb_bbbb_bbbb, 8'h3c, 0);
        cur_req = "R10";
        store(32'h0000_2018, 64'hdead_beef_cafe_f00d, 8'ha5, 0);
        cur_req = "R7";
        flush_now();
        idle(5);

        // R4 other line while open; store held through the drain
        cur_req = "R4";
        store(32'h0000_3010, 64'h5555_6666_7777_8888, 8'hf0, 0);
        store(32'h0000_3028, 64'h9999_0000_1111_2222, 8'h0f, 0);
        cur_req = "R8";
        store(32'h0000_4000, 64'h0bad_0bad_0bad_0bad, 8'hff, 0);
        cur_req = "R4";
        flush_now();
        idle(4);

        // R6 full line drains by itself
        cur_req = "R6";
        for (int b = 0; b < NB; b++)
            store(32'h0000_5000 + 32'(b*8), {8{8'(b+8'h40)}}, 8'hff, 0);
        idle(10);

        // R5 flush with nothing open
        cur_req = "R5";
        flush_now();
        flush_now();
        idle(2);
        // store with flush in the same cycle
        store(32'h0000_6020, 64'h0123_4567_89ab_cdef, 8'h18, 1);
        idle(3);

        // mixed random traffic over two lines
        cur_req = "R7";
        for (int k = 0; k < 3000; k++) begin
            st_valid = ($urandom % 3) != 0;
            st_addr  = {26'($urandom % 2) + 26'h100, 3'($urandom)};
            st_data  = {$urandom, $urandom};
            st_be    = 8'($urandom);
            flush    = ($urandom % 16) == 0;
            step();
        end
        idle(12);

        done = 1;
        summary();
        $finish;
    end
endmodule